// File: doc/BRIEF.md
# Serial Receive Condition Status Register

This block keeps the per-character error and end-of-frame status for a serial receiver that runs in one of three modes: asynchronous, character-synchronous, or bit-oriented framing with flags and a frame check. The receiver front end gives a one-cycle strobe each time a character completes. With each strobe it gives the condition flags for that character: closing flag seen, CRC mismatch, framing error, parity error, overrun, the residue bits and the transmitter all-sent level. The block merges these into one 8-bit status word that software or a sequencer reads.

The bits follow different retention rules. Parity and overrun are sticky until an error-reset command. The CRC/framing bit is rewritten by every character. The end-of-frame bit and the residue code are tied to the framing mode and to the frame boundary. In asynchronous mode the block also sends the receiver a one-cycle request to stretch the character by half a bit after a framing error. This keeps the bad stop bit from being taken as a new start bit.

Top module: `rx_cond_status`

## Requirements
- R1: After reset, `rd_data` is 8'h00 and `half_bit_req` is 0, provided `all_sent_in` is low.
- R2: The read word has the end-of-frame bit at bit 7 and CRC/framing at bit 6. Overrun is at bit 5 and parity at bit 4. Residue bit 0 is at bit 3, residue bit 1 at bit 2 and residue bit 2 at bit 1. Bit 0 is `all_sent_in` delayed by one clock.
- R3: In framing mode (`mode` = 2'b10), a character strobe sets bit 7 to the strobe's `flag_close`. A strobe with a closing flag sets it, and the next strobe without one clears it.
- R4: The cycle after `mode` is anything other than 2'b10, bit 7 and bits 3..1 read 0. Strobes with `flag_close` in those modes leave them at 0.
- R5: In asynchronous mode (`mode` = 2'b00), each strobe writes `frame_err` into bit 6 and `crc_bad` has no effect. The bit is not latched: a clean character clears it.
- R6: In synchronous mode (2'b01), in framing mode, and in the spare code 2'b11 (handled as synchronous), each strobe writes `crc_bad` into bit 6 and `frame_err` has no effect.
- R7: An `err_reset` cycle with no strobe clears bits 7..4 by the next cycle. It leaves the residue bits unchanged.
- R8: Parity (bit 4) and overrun (bit 5) are set by a strobe carrying the flag. They stay set through later clean strobes until `err_reset`.
- R9: When `err_reset` and a strobe fall in the same cycle, bits 7..4 take exactly that character's values. Sticky history from before is dropped.
- R10: In framing mode, a strobe with a closing flag loads the residue bits from `res_in`. They hold while no strobe arrives. The next strobe without a closing flag clears them to 0.
- R11: `half_bit_req` is high for exactly the one cycle after an asynchronous-mode strobe with `frame_err` set. It never rises in the other modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mode | input | 2 | 00 async, 01 sync, 10 bit-oriented framing, 11 handled as sync |
| chr_done | input | 1 | One-cycle strobe, character complete |
| flag_close | input | 1 | Closing flag ended this character (framing mode) |
| crc_bad | input | 1 | CRC checker does not match the expected value |
| frame_err | input | 1 | Stop bit missing on this character (async) |
| par_err | input | 1 | Parity mismatch on this character |
| ovr_err | input | 1 | Character lost to a full receive buffer |
| res_in | input | 3 | Residue bits for the closing character |
| all_sent_in | input | 1 | Transmitter all-sent level |
| err_reset | input | 1 | Error-reset command, one cycle |
| rd_data | output | 8 | Status word |
| half_bit_req | output | 1 | Request to extend the current character by half a bit |

## Verification
A wrong retention state shows on `rd_data` the cycle after the next strobe or error-reset. A sticky bit that leaks, or a CRC/framing bit that latches, reads back wrong after one clean character. A stale end-of-frame or residue value shows when the next frame's first character fails to clear it, or when a mode change fails to zero it. The collision case and the half-bit pulse need a cycle-exact look: a swapped priority or a pulse held too long shows only in the single cycle after the event.

// File: rtl/rxcs_pkg.sv
package rxcs_pkg;

  typedef enum logic [1:0] {
    RXM_ASYNC = 2'b00,
    RXM_SYNC  = 2'b01,
    RXM_FRAME = 2'b10,
    RXM_SPARE = 2'b11
  } rx_mode_e;

  localparam int N_STICKY = 2;
  localparam int STK_PAR  = 0;
  localparam int STK_OVR  = 1;

endpackage

// File: rtl/rxcs_rst_sync.sv
module rxcs_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= sh_d;
  end

  assign rst_sync_n = sh_q[STAGES-1];

endmodule

// File: rtl/rxcs_frame_trk.sv
// End-of-frame flag and residue code, valid only in framing mode.
module rxcs_frame_trk #(
  parameter int RES_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_frame,
  input  logic             chr_done,
  input  logic             err_reset,
  input  logic             flag_close,
  input  logic [RES_W-1:0] res_in,
  output logic             eof,
  output logic [RES_W-1:0] res
);

  logic             eof_q, eof_d;
  logic [RES_W-1:0] res_q, res_d;
  logic             upd_en;

  always_comb begin
    eof_d = eof_q;
    res_d = res_q;
    if (!in_frame) begin
      eof_d = 1'b0;
      res_d = '0;
    end else if (chr_done) begin
      eof_d = flag_close;
      res_d = flag_close ? res_in : '0;
    end else if (err_reset) begin
      eof_d = 1'b0;
    end
  end

  assign upd_en = !in_frame || chr_done || err_reset;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      eof_q <= 1'b0;
      res_q <= '0;
    end else if (upd_en) begin
      eof_q <= eof_d;
      res_q <= res_d;
    end
  end

  assign eof = eof_q;
  assign res = res_q;

endmodule

// File: rtl/rxcs_err_bits.sv
// Per-character CRC/framing bit, sticky error bits, half-bit request pulse.
module rxcs_err_bits #(
  parameter int NSTK = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            async_mode,
  input  logic            chr_done,
  input  logic            err_reset,
  input  logic            frame_err,
  input  logic            crc_bad,
  input  logic [NSTK-1:0] stk_in,
  output logic            crcfe,
  output logic [NSTK-1:0] stk,
  output logic            half_bit_req
);

  logic crcfe_q, crcfe_d;
  logic hb_q, hb_d;
  logic upd_en;

  assign upd_en = chr_done || err_reset;

  always_comb begin
    crcfe_d = crcfe_q;
    if (chr_done)       crcfe_d = async_mode ? frame_err : crc_bad;
    else if (err_reset) crcfe_d = 1'b0;
    hb_d = chr_done && async_mode && frame_err;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) crcfe_q <= 1'b0;
    else if (upd_en) crcfe_q <= crcfe_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hb_q <= 1'b0;
    else        hb_q <= hb_d;
  end

  for (genvar i = 0; i < NSTK; i++) begin : g_stk
    logic s_q, s_d;
    always_comb begin
      s_d = s_q;
      if (chr_done && err_reset) s_d = stk_in[i];
      else if (chr_done)         s_d = s_q | stk_in[i];
      else if (err_reset)        s_d = 1'b0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) s_q <= 1'b0;
      else if (upd_en) s_q <= s_d;
    end
    assign stk[i] = s_q;
  end

  assign crcfe        = crcfe_q;
  assign half_bit_req = hb_q;

endmodule

// File: rtl/rxcs_rd_pack.sv
// Assembles the status word; residue bit i lands at position RES_W-i.
module rxcs_rd_pack #(
  parameter int RES_W = 3
) (
  input  logic             eof,
  input  logic             crcfe,
  input  logic             ovr,
  input  logic             par,
  input  logic [RES_W-1:0] res,
  input  logic             all_sent,
  output logic [RES_W+4:0] rd
);

  localparam int TOP = RES_W + 4;

  assign rd[TOP]   = eof;
  assign rd[TOP-1] = crcfe;
  assign rd[TOP-2] = ovr;
  assign rd[TOP-3] = par;
  assign rd[0]     = all_sent;

  for (genvar i = 0; i < RES_W; i++) begin : g_res
    assign rd[RES_W-i] = res[i];
  end

endmodule

// File: rtl/rx_cond_status.sv
module rx_cond_status
  import rxcs_pkg::*;
#(
  parameter int RES_W     = 3,
  parameter int RST_STAGE = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             chr_done,
  input  logic             flag_close,
  input  logic             crc_bad,
  input  logic             frame_err,
  input  logic             par_err,
  input  logic             ovr_err,
  input  logic [RES_W-1:0] res_in,
  input  logic             all_sent_in,
  input  logic             err_reset,
  output logic [RES_W+4:0] rd_data,
  output logic             half_bit_req
);

  logic                rst_sync_n;
  logic                in_frame, async_mode;
  logic                eof;
  logic [RES_W-1:0]    res;
  logic                crcfe;
  logic [N_STICKY-1:0] stk_in, stk;
  logic                all_sent_q;

  assign in_frame   = (rx_mode_e'(mode) == RXM_FRAME);
  assign async_mode = (rx_mode_e'(mode) == RXM_ASYNC);

  assign stk_in[STK_PAR] = par_err;
  assign stk_in[STK_OVR] = ovr_err;

  rxcs_rst_sync #(.STAGES(RST_STAGE)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  rxcs_frame_trk #(.RES_W(RES_W)) u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .in_frame   (in_frame),
    .chr_done   (chr_done),
    .err_reset  (err_reset),
    .flag_close (flag_close),
    .res_in     (res_in),
    .eof        (eof),
    .res        (res)
  );

  rxcs_err_bits #(.NSTK(N_STICKY)) u_err (
    .clk          (clk),
    .rst_n        (rst_sync_n),
    .async_mode   (async_mode),
    .chr_done     (chr_done),
    .err_reset    (err_reset),
    .frame_err    (frame_err),
    .crc_bad      (crc_bad),
    .stk_in       (stk_in),
    .crcfe        (crcfe),
    .stk          (stk),
    .half_bit_req (half_bit_req)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) all_sent_q <= 1'b0;
    else             all_sent_q <= all_sent_in;
  end

  rxcs_rd_pack #(.RES_W(RES_W)) u_pack (
    .eof      (eof),
    .crcfe    (crcfe),
    .ovr      (stk[STK_OVR]),
    .par      (stk[STK_PAR]),
    .res      (res),
    .all_sent (all_sent_q),
    .rd       (rd_data)
  );

endmodule

// File: rtl/rx_cond_status_chk.sv
module rx_cond_status_chk
  import rxcs_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       chr_done,
  input logic       flag_close,
  input logic       crc_bad,
  input logic       frame_err,
  input logic       par_err,
  input logic       ovr_err,
  input logic [2:0] res_in,
  input logic       all_sent_in,
  input logic       err_reset,
  input logic [7:0] rd_data,
  input logic       half_bit_req
);

  // R2
  all_sent_hi_chk: assert property (@(posedge clk) disable iff (!rst_n)
    all_sent_in |=> rd_data[0]);
  // R2
  all_sent_lo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !all_sent_in |=> !rd_data[0]);
  // R4
  nonframe_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != RXM_FRAME) |=> (rd_data[7] == 1'b0) && (rd_data[3:1] == 3'b000));
  // R5
  async_fe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && mode == RXM_ASYNC) |=> rd_data[6] == $past(frame_err));
  // R6
  sync_crc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && mode != RXM_ASYNC) |=> rd_data[6] == $past(crc_bad));
  // R7
  err_reset_clr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_reset && !chr_done) |=> rd_data[7:4] == 4'h0);
  // R8
  par_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[4] && !err_reset) |=> rd_data[4]);
  // R8
  ovr_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_data[5] && !err_reset) |=> rd_data[5]);
  // R9
  collide_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && err_reset) |=> (rd_data[4] == $past(par_err)) && (rd_data[5] == $past(ovr_err)));
  // R10
  residue_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (chr_done && flag_close && mode == RXM_FRAME) |=>
      (rd_data[7] && rd_data[3:1] == {$past(res_in[0]), $past(res_in[1]), $past(res_in[2])}));
  // R11
  half_bit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    half_bit_req |-> $past(chr_done && frame_err && mode == RXM_ASYNC));
  // R11
  half_bit_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (half_bit_req && !chr_done) |=> !half_bit_req);

endmodule

bind rx_cond_status rx_cond_status_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_sync_n),
  .mode         (mode),
  .chr_done     (chr_done),
  .flag_close   (flag_close),
  .crc_bad      (crc_bad),
  .frame_err    (frame_err),
  .par_err      (par_err),
  .ovr_err      (ovr_err),
  .res_in       (res_in),
  .all_sent_in  (all_sent_in),
  .err_reset    (err_reset),
  .rd_data      (rd_data),
  .half_bit_req (half_bit_req)
);

// File: tb/rx_cond_status_bench.sv
`timescale 1ns/1ps
module rx_cond_status_bench;

  logic       clk;
  logic       rst_n;
  logic [1:0] mode;
  logic       chr_done, flag_close, crc_bad, frame_err, par_err, ovr_err;
  logic [2:0] res_in;
  logic       all_sent_in, err_reset;
  logic [7:0] rd_data;
  logic       half_bit_req;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  rx_cond_status u_rx_cond_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .mode         (mode),
    .chr_done     (chr_done),
    .flag_close   (flag_close),
    .crc_bad      (crc_bad),
    .frame_err    (frame_err),
    .par_err      (par_err),
    .ovr_err      (ovr_err),
    .res_in       (res_in),
    .all_sent_in  (all_sent_in),
    .err_reset    (err_reset),
    .rd_data      (rd_data),
    .half_bit_req (half_bit_req)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s rd_data actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk1(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s half_bit_req actual=%b expected=%b", tag, act, exp);
    end
  endtask

  // One character strobe; on return the result of that strobe is visible.
  task automatic send_chr(input logic fl, input logic crc, input logic fe,
                          input logic par, input logic ovr, input logic [2:0] res,
                          input logic er);
    @(negedge clk);
    chr_done = 1'b1; flag_close = fl; crc_bad = crc; frame_err = fe;
    par_err = par; ovr_err = ovr; res_in = res; err_reset = er;
    @(negedge clk);
    chr_done = 1'b0; flag_close = 1'b0; crc_bad = 1'b0; frame_err = 1'b0;
    par_err = 1'b0; ovr_err = 1'b0; res_in = 3'b000; err_reset = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clean_state(input logic [1:0] next_mode);
    @(negedge clk);
    mode = 2'b00; all_sent_in = 1'b0; err_reset = 1'b1;
    @(negedge clk);
    err_reset = 1'b0;
    chk8("R7 clean", rd_data, 8'h00);
    mode = next_mode;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk8("R1 reset word", rd_data, 8'h00);
    chk1("R1 reset pulse", half_bit_req, 1'b0);
  endtask

  task automatic t_layout;
    clean_state(2'b10);
    send_chr(1, 1, 0, 1, 1, 3'b001, 0);
    chk8("R2 layout eof/crc/ovr/par/res0", rd_data, 8'hF8);
    clean_state(2'b10);
    send_chr(1, 0, 0, 0, 0, 3'b100, 0);
    chk8("R2 layout res2 at bit1", rd_data, 8'h82);
    all_sent_in = 1'b1;
    @(negedge clk);
    chk8("R2 all-sent bit0", rd_data, 8'h83);
    all_sent_in = 1'b0;
  endtask

  task automatic t_eof;
    clean_state(2'b10);
    send_chr(0, 1, 0, 0, 0, 3'b000, 0);
    chk8("R3 mid-frame char", rd_data, 8'h40);
    send_chr(1, 0, 0, 0, 0, 3'b011, 0);
    chk8("R3 closing flag sets eof", rd_data, 8'h8C);
    idle(3);
    chk8("R10 residue held while idle", rd_data, 8'h8C);
    send_chr(0, 1, 0, 0, 0, 3'b111, 0);
    chk8("R3 R10 next frame first char clears", rd_data, 8'h40);
  endtask

  task automatic t_mode_exit;
    clean_state(2'b10);
    send_chr(1, 0, 0, 0, 0, 3'b111, 0);
    chk8("R4 set in frame mode", rd_data, 8'h8E);
    mode = 2'b01;
    @(negedge clk);
    chk8("R4 leave frame mode zeroes", rd_data, 8'h00);
    send_chr(1, 0, 0, 0, 0, 3'b111, 0);
    chk8("R4 sync closing flag ignored", rd_data, 8'h00);
    mode = 2'b00;
    send_chr(1, 0, 0, 0, 0, 3'b101, 0);
    chk8("R4 async closing flag ignored", rd_data, 8'h00);
  endtask

  task automatic t_async;
    clean_state(2'b00);
    send_chr(0, 0, 1, 0, 0, 3'b000, 0);
    chk8("R5 framing error shown", rd_data, 8'h40);
    chk1("R11 extend pulse high", half_bit_req, 1'b1);
    @(negedge clk);
    chk1("R11 extend pulse one cycle", half_bit_req, 1'b0);
    send_chr(0, 0, 0, 0, 0, 3'b000, 0);
    chk8("R5 not latched", rd_data, 8'h00);
    send_chr(0, 1, 0, 0, 0, 3'b000, 0);
    chk8("R5 crc ignored in async", rd_data, 8'h00);
  endtask

  task automatic t_sync;
    clean_state(2'b01);
    send_chr(0, 1, 0, 0, 0, 3'b000, 0);
    chk8("R6 sync crc bad", rd_data, 8'h40);
    send_chr(0, 0, 1, 0, 0, 3'b000, 0);
    chk8("R6 sync crc good, fe ignored", rd_data, 8'h00);
    chk1("R11 no pulse in sync", half_bit_req, 1'b0);
    mode = 2'b11;
    send_chr(0, 1, 0, 0, 0, 3'b000, 0);
    chk8("R6 spare mode acts as sync", rd_data, 8'h40);
    mode = 2'b10;
    send_chr(1, 0, 1, 0, 0, 3'b000, 0);
    chk8("R6 frame crc good", rd_data, 8'h80);
  endtask

  task automatic t_err_reset;
    clean_state(2'b10);
    send_chr(1, 1, 0, 1, 1, 3'b010, 0);
    chk8("R7 before reset", rd_data, 8'hF4);
    @(negedge clk);
    err_reset = 1'b1;
    @(negedge clk);
    err_reset = 1'b0;
    chk8("R7 error reset keeps residue", rd_data, 8'h04);
  endtask

  task automatic t_sticky;
    clean_state(2'b00);
    send_chr(0, 0, 0, 1, 0, 3'b000, 0);
    chk8("R8 parity set", rd_data, 8'h10);
    send_chr(0, 0, 0, 0, 0, 3'b000, 0);
    chk8("R8 parity held", rd_data, 8'h10);
    send_chr(0, 0, 0, 0, 1, 3'b000, 0);
    chk8("R8 overrun added", rd_data, 8'h30);
    send_chr(0, 0, 0, 0, 0, 3'b000, 0);
    chk8("R8 both held", rd_data, 8'h30);
  endtask

  task automatic t_collide;
    clean_state(2'b00);
    send_chr(0, 0, 0, 1, 1, 3'b000, 0);
    chk8("R9 setup", rd_data, 8'h30);
    send_chr(0, 0, 1, 0, 1, 3'b000, 1);
    chk8("R9 new char wins over reset", rd_data, 8'h60);
    clean_state(2'b10);
    send_chr(1, 1, 0, 0, 0, 3'b001, 1);
    chk8("R9 eof from colliding char", rd_data, 8'hC8);
  endtask

  initial begin
    rst_n = 1'b0; mode = 2'b00; chr_done = 1'b0; flag_close = 1'b0;
    crc_bad = 1'b0; frame_err = 1'b0; par_err = 1'b0; ovr_err = 1'b0;
    res_in = 3'b000; all_sent_in = 1'b0; err_reset = 1'b0;
    idle(4);
    rst_n = 1'b1;
    idle(4);
    t_reset();
    t_layout();
    t_eof();
    t_mode_exit();
    t_async();
    t_sync();
    t_err_reset();
    t_sticky();
    t_collide();
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule